// File: doc/BRIEF.md
# Speculative Two-Stage Context-Adaptive Bin Decoder

The block turns a serial stream of arithmetic-coded bits into binary decisions (bins). It holds a 9-bit interval width and a 9-bit offset into that interval. For each bin it splits the interval into a likely part and an unlikely part, sized from an adaptive probability estimate. It reports which part the offset falls in, then updates the estimate and refills the interval from the stream. It keeps its own table of 64 adaptive probability contexts. Elements may also be decoded with fixed, equal probabilities (bypass mode).

Work is split over two stages. Stage one selects the context for the next bin. It prepares two candidates, one that follows a decoded 0 and one that follows a decoded 1, and the bin leaving stage two picks between them in the same cycle. Stage two does the subdivision, the offset comparison, the context adaptation and the interval refill. Because the next context is already chosen when a bin resolves, one bin per clock can leave the block whenever no refill bits are needed.

A user loads a starting context index with a start pulse. The block then decodes one truncated-unary element and flags its last bin.

Top module: `spec_bin_decoder`

## Requirements
- R1: After reset the block fetches 9 stream bits with `bit_ready_o` high and shifts them into the offset, most significant bit first, with the width set to 510. No bin is reported during this phase.
- R2: For a context bin with 6-bit state s and width bits q = width[7:6], the unlikely part is P(s)·32·(2q+9)/65536 rounded down, with a floor of 6. Here P(0)=32768 and P(s+1)=⌊P(s)·243/256⌋. The likely part is the width minus the unlikely part. An offset at or above the likely part decodes the unlikely value: the offset is reduced by the likely part and the width becomes the unlikely part. Otherwise the likely value is decoded and the width becomes the likely part.
- R3: All contexts reset to state 0 with likely value 0. After a likely-value decode the state rises by one, saturating at 62. After an unlikely-value decode the state becomes s−1−⌊s/4⌋ (0 stays 0), and from state 0 the likely value flips.
- R4: While the width is below 256, it and the offset are doubled, one per cycle, and each step appends the next stream bit in arrival order at the offset's least significant position.
- R5: A bypass bin appends one stream bit to form a 10-bit value 2·offset+bit. It decodes 1, and subtracts the width, when that value is at least the width; otherwise it decodes 0. The width and the context table are left unchanged.
- R6: Elements are truncated unary. Bin k (from 0) uses context (base + min(k,3)) mod 64. A 0 bin or the 8th bin ends the element, and `se_done_o` is high together with that bin's `bin_valid_o`.
- R7: Once a bin resolves, the next bin of the same element may resolve in the following cycle, and it sees the context state as updated by the bin before it, even when both use the same context.
- R8: A stream bit is taken only in a cycle where `bit_valid_i` and `bit_ready_o` are both high. With no valid bit, a waiting bypass bin or refill does not advance. `bit_ready_o` is low while no element is pending and no refill is due.
- R9: A start pulse while an element is still in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin an element (accepted when idle) |
| start_ctx_i | input | 6 | Base context index of the element |
| start_bypass_i | input | 1 | Decode the element with fixed equal probabilities |
| bit_i | input | 1 | Next stream bit |
| bit_valid_i | input | 1 | `bit_i` holds a bit |
| bit_ready_o | output | 1 | Block takes a bit this cycle if valid |
| bin_valid_o | output | 1 | A bin is reported this cycle |
| bin_o | output | 1 | Decoded bin value |
| se_done_o | output | 1 | This bin ends the element |

## Verification
The bench builds the block with its default values: 64 contexts, 8 bins per element and a 4-context unary span. These settings are small enough that a sweep can start an element on every context index several times, so each table entry climbs and falls through many states. The span makes long runs of 1 bins revisit the same context on consecutive bins, which exercises the forwarding path. A pseudo-random bit stream, delivered gap-free, with periodic gaps and with a full stall, is decoded alongside an arithmetic model built from the rules above, bin by bin.

// File: rtl/sbd_pkg.sv
package sbd_pkg;

    localparam int RNG_W    = 9;
    localparam int ST_W     = 6;
    localparam int ST_MAX   = 62;
    localparam int LPS_W    = 8;
    localparam int RNG_INIT = 510;

    typedef struct packed {
        logic            mps;
        logic [ST_W-1:0] st;
    } ctx_state_t;

    typedef enum logic [1:0] {
        M_INIT   = 2'd0,
        M_RUN    = 2'd1,
        M_RENORM = 2'd2
    } dec_mode_e;

    // probability of the unlikely value in Q16, decaying geometrically with state
    function automatic int unlikely_prob(input int s);
        int p;
        p = 32768;
        for (int i = 0; i < s; i++) p = (p * 243) >> 8;
        return p;
    endfunction

    // unlikely subrange width for a state and a quarter of the interval
    function automatic int unlikely_width(input int s, input int q);
        int v;
        v = (unlikely_prob(s) * 32 * (2 * q + 9)) >> 16;
        if (v < 6) v = 6;
        return v;
    endfunction

    function automatic logic [ST_W-1:0] st_on_likely(input logic [ST_W-1:0] s);
        return (s >= ST_W'(ST_MAX)) ? ST_W'(ST_MAX) : s + ST_W'(1);
    endfunction

    function automatic logic [ST_W-1:0] st_on_unlikely(input logic [ST_W-1:0] s);
        return (s == '0) ? '0 : s - ST_W'(1) - (s >> 2);
    endfunction

endpackage

// File: rtl/sbd_lps_rom.sv
module sbd_lps_rom
    import sbd_pkg::*;
(
    input  logic [ST_W-1:0]  st_i,
    input  logic [1:0]       q_i,
    output logic [LPS_W-1:0] lps_o
);
    localparam int N_ST = 1 << ST_W;

    logic [LPS_W-1:0] tab [N_ST][4];

    for (genvar s = 0; s < N_ST; s++) begin : g_st
        for (genvar q = 0; q < 4; q++) begin : g_q
            localparam int W = unlikely_width(s, q);
            assign tab[s][q] = LPS_W'(W);
        end
    end

    assign lps_o = tab[st_i][q_i];
endmodule

// File: rtl/sbd_ctx_store.sv
module sbd_ctx_store
    import sbd_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int NRD   = 3,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we_i,
    input  logic [AW-1:0] waddr_i,
    input  ctx_state_t wdata_i,
    input  logic [AW-1:0] raddr_i [NRD],
    output ctx_state_t rdata_o [NRD]
);
    ctx_state_t mem_q [DEPTH];
    ctx_state_t mem_d [DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (we_i) mem_d[waddr_i] = wdata_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    // a read of the entry being written this cycle returns the new value
    for (genvar r = 0; r < NRD; r++) begin : g_rd
        assign rdata_o[r] = (we_i && (waddr_i == raddr_i[r])) ? wdata_i : mem_q[raddr_i[r]];
    end
endmodule

// File: rtl/sbd_next_ctx.sv
module sbd_next_ctx
    import sbd_pkg::*;
#(
    parameter int CTX_W    = 6,
    parameter int MAX_BINS = 8,
    parameter int CTX_SPAN = 4,
    parameter int K_W      = $clog2(MAX_BINS)
) (
    input  logic [CTX_W-1:0] base_i,
    input  logic [K_W-1:0]   k_i,
    input  logic             bin_i,
    output logic [CTX_W-1:0] cand_ctx_o [2],
    input  ctx_state_t       cand_cs_i [2],
    output logic             nxt_v_o,
    output logic [CTX_W-1:0] nxt_ctx_o,
    output logic [K_W-1:0]   nxt_k_o,
    output ctx_state_t       nxt_cs_o
);
    localparam logic [K_W-1:0] K_LAST  = K_W'(MAX_BINS - 1);
    localparam logic [K_W-1:0] OFF_TOP = K_W'(CTX_SPAN - 1);

    logic           cand_v [2];
    logic [K_W-1:0] cand_k [2];

    // one candidate per possible value of the bin still being decoded
    for (genvar g = 0; g < 2; g++) begin : g_cand
        logic [K_W-1:0] off;
        assign cand_k[g]     = k_i + K_W'(1);
        assign cand_v[g]     = (g != 0) && (k_i != K_LAST);
        assign off           = (cand_k[g] > OFF_TOP) ? OFF_TOP : cand_k[g];
        assign cand_ctx_o[g] = base_i + CTX_W'(off);
    end

    assign nxt_v_o   = bin_i ? cand_v[1]     : cand_v[0];
    assign nxt_ctx_o = bin_i ? cand_ctx_o[1] : cand_ctx_o[0];
    assign nxt_k_o   = bin_i ? cand_k[1]     : cand_k[0];
    assign nxt_cs_o  = bin_i ? cand_cs_i[1]  : cand_cs_i[0];
endmodule

// File: rtl/spec_bin_decoder.sv
module spec_bin_decoder
    import sbd_pkg::*;
#(
    parameter int CTX_DEPTH = 64,
    parameter int MAX_BINS  = 8,
    parameter int CTX_SPAN  = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start_i,
    input  logic [$clog2(CTX_DEPTH)-1:0] start_ctx_i,
    input  logic                         start_bypass_i,
    input  logic                         bit_i,
    input  logic                         bit_valid_i,
    output logic                         bit_ready_o,
    output logic                         bin_valid_o,
    output logic                         bin_o,
    output logic                         se_done_o
);
    localparam int CTX_W = $clog2(CTX_DEPTH);
    localparam int K_W   = $clog2(MAX_BINS);
    localparam int CNT_W = $clog2(RNG_W + 1);

    typedef struct packed {
        dec_mode_e        mode;
        logic [CNT_W-1:0] icnt;
        logic [RNG_W-1:0] rng;
        logic [RNG_W-1:0] off;
        logic             slot_v;
        logic [CTX_W-1:0] slot_ctx;
        logic [K_W-1:0]   slot_k;
        ctx_state_t       slot_cs;
        logic [CTX_W-1:0] base;
        logic             byp;
        logic             bin_v;
        logic             bin;
        logic             done;
    } dec_reg_t;

    dec_reg_t r_q, r_d;

    // stage one: speculative next-context selection
    logic [CTX_W-1:0] rd_addr [3];
    ctx_state_t       rd_data [3];
    logic [CTX_W-1:0] cand_ctx [2];
    ctx_state_t       cand_cs [2];
    logic             nxt_v;
    logic [CTX_W-1:0] nxt_ctx;
    logic [K_W-1:0]   nxt_k;
    ctx_state_t       nxt_cs;
    logic             bin_val;

    // stage two datapath
    logic             wr_en;
    ctx_state_t       wr_cs;
    logic [LPS_W-1:0] lps;
    logic [RNG_W-1:0] rmps;
    logic [RNG_W:0]   ext, ext_sub;
    logic             byp_hit, lps_hit, take, fire;

    assign rd_addr[0]  = cand_ctx[0];
    assign rd_addr[1]  = cand_ctx[1];
    assign rd_addr[2]  = start_ctx_i;
    assign cand_cs[0]  = rd_data[0];
    assign cand_cs[1]  = rd_data[1];

    sbd_next_ctx #(
        .CTX_W(CTX_W), .MAX_BINS(MAX_BINS), .CTX_SPAN(CTX_SPAN), .K_W(K_W)
    ) u_next (
        .base_i(r_q.base), .k_i(r_q.slot_k), .bin_i(bin_val),
        .cand_ctx_o(cand_ctx), .cand_cs_i(cand_cs),
        .nxt_v_o(nxt_v), .nxt_ctx_o(nxt_ctx), .nxt_k_o(nxt_k), .nxt_cs_o(nxt_cs)
    );

    sbd_ctx_store #(.DEPTH(CTX_DEPTH), .NRD(3), .AW(CTX_W)) u_store (
        .clk(clk), .rst_n(rst_n), .we_i(wr_en), .waddr_i(r_q.slot_ctx),
        .wdata_i(wr_cs), .raddr_i(rd_addr), .rdata_o(rd_data)
    );

    sbd_lps_rom u_rom (.st_i(r_q.slot_cs.st), .q_i(r_q.rng[7:6]), .lps_o(lps));

    assign bit_ready_o = (r_q.mode == M_INIT) || (r_q.mode == M_RENORM) ||
                         ((r_q.mode == M_RUN) && r_q.slot_v && r_q.byp);
    assign take    = bit_valid_i && bit_ready_o;
    assign rmps    = r_q.rng - RNG_W'(lps);
    assign lps_hit = (r_q.off >= rmps);
    assign ext     = {r_q.off, bit_i};
    assign byp_hit = (ext >= {1'b0, r_q.rng});
    assign ext_sub = ext - {1'b0, r_q.rng};
    assign bin_val = r_q.byp ? byp_hit : (lps_hit ? ~r_q.slot_cs.mps : r_q.slot_cs.mps);
    assign fire    = (r_q.mode == M_RUN) && r_q.slot_v && (!r_q.byp || bit_valid_i);

    always_comb begin
        r_d       = r_q;
        r_d.bin_v = 1'b0;
        r_d.done  = 1'b0;
        wr_en     = 1'b0;
        wr_cs     = r_q.slot_cs;

        unique case (r_q.mode)
            M_INIT: if (take) begin
                r_d.off  = {r_q.off[RNG_W-2:0], bit_i};
                r_d.icnt = r_q.icnt + CNT_W'(1);
                if (r_q.icnt == CNT_W'(RNG_W - 1)) r_d.mode = M_RUN;
            end
            M_RENORM: if (take) begin
                r_d.rng = {r_q.rng[RNG_W-2:0], 1'b0};
                r_d.off = {r_q.off[RNG_W-2:0], bit_i};
                if (r_q.rng[RNG_W-2]) r_d.mode = M_RUN;
            end
            default: if (fire) begin
                if (r_q.byp) begin
                    r_d.off = byp_hit ? ext_sub[RNG_W-1:0] : ext[RNG_W-1:0];
                end else begin
                    wr_en = 1'b1;
                    if (lps_hit) begin
                        r_d.rng  = RNG_W'(lps);
                        r_d.off  = r_q.off - rmps;
                        wr_cs.st = st_on_unlikely(r_q.slot_cs.st);
                        if (r_q.slot_cs.st == '0) wr_cs.mps = ~r_q.slot_cs.mps;
                    end else begin
                        r_d.rng  = rmps;
                        wr_cs.st = st_on_likely(r_q.slot_cs.st);
                    end
                    if (!r_d.rng[RNG_W-1]) r_d.mode = M_RENORM;
                end
                r_d.bin_v    = 1'b1;
                r_d.bin      = bin_val;
                r_d.done     = !nxt_v;
                r_d.slot_v   = nxt_v;
                r_d.slot_ctx = nxt_ctx;
                r_d.slot_k   = nxt_k;
                r_d.slot_cs  = nxt_cs;
            end
        endcase

        if (start_i && !r_q.slot_v) begin
            r_d.slot_v   = 1'b1;
            r_d.slot_ctx = start_ctx_i;
            r_d.slot_k   = '0;
            r_d.slot_cs  = rd_data[2];
            r_d.base     = start_ctx_i;
            r_d.byp      = start_bypass_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.mode <= M_INIT;
            r_q.rng  <= RNG_W'(RNG_INIT);
        end else begin
            r_q <= r_d;
        end
    end

    assign bin_valid_o = r_q.bin_v;
    assign bin_o       = r_q.bin;
    assign se_done_o   = r_q.done;

    // views of internal state for the bound checker
    logic             chk_run, chk_init;
    logic [RNG_W-1:0] chk_rng, chk_off;
    logic             chk_slot_v, chk_byp;
    logic [CTX_W-1:0] chk_base;
    assign chk_run    = (r_q.mode == M_RUN);
    assign chk_init   = (r_q.mode == M_INIT);
    assign chk_rng    = r_q.rng;
    assign chk_off    = r_q.off;
    assign chk_slot_v = r_q.slot_v;
    assign chk_byp    = r_q.byp;
    assign chk_base   = r_q.base;
endmodule

// File: rtl/sbd_checker.sv
module sbd_checker #(
    parameter int MAX_BINS = 8,
    parameter int CTX_W    = 6,
    parameter int RNG_W    = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             bit_valid_i,
    input logic             bin_valid_o,
    input logic             bin_o,
    input logic             se_done_o,
    input logic             chk_run,
    input logic             chk_init,
    input logic [RNG_W-1:0] chk_rng,
    input logic [RNG_W-1:0] chk_off,
    input logic             chk_slot_v,
    input logic             chk_byp,
    input logic [CTX_W-1:0] chk_base
);
    int bins_in_el;

    always_ff @(posedge clk) begin
        if (!rst_n) bins_in_el <= 0;
        else if (bin_valid_o) bins_in_el <= se_done_o ? 0 : bins_in_el + 1;
    end

    p_no_bin_init_r1: assert property (@(posedge clk) disable iff (!rst_n)
        chk_init |-> !bin_valid_o);

    p_off_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_init |-> (chk_off < chk_rng));

    p_normalised_r4: assert property (@(posedge clk) disable iff (!rst_n)
        chk_run |-> chk_rng[RNG_W-1]);

    p_done_with_bin_r6: assert property (@(posedge clk) disable iff (!rst_n)
        se_done_o |-> bin_valid_o);

    p_zero_ends_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bin_valid_o && !bin_o) |-> se_done_o);

    p_max_bins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bin_valid_o && (bins_in_el == MAX_BINS - 1)) |-> se_done_o);

    p_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_run && chk_slot_v && chk_byp && !bit_valid_i) |=> !bin_valid_o);

    p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_slot_v && start_i) |=> $stable(chk_base));
endmodule

bind spec_bin_decoder sbd_checker #(
    .MAX_BINS(MAX_BINS), .CTX_W(CTX_W), .RNG_W(sbd_pkg::RNG_W)
) u_sbd_checker (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .bit_valid_i(bit_valid_i),
    .bin_valid_o(bin_valid_o), .bin_o(bin_o), .se_done_o(se_done_o),
    .chk_run(chk_run), .chk_init(chk_init), .chk_rng(chk_rng), .chk_off(chk_off),
    .chk_slot_v(chk_slot_v), .chk_byp(chk_byp), .chk_base(chk_base)
);

// File: tb/tb_spec_bin_decoder.sv
`timescale 1ns/1ps
module tb_spec_bin_decoder;
    localparam int NBITS = 65536;
    localparam int MAXB  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic [5:0] start_ctx_i = '0;
    logic start_bypass_i = 1'b0;
    logic bit_i = 1'b0;
    logic bit_valid_i = 1'b0;
    logic bit_ready_o, bin_valid_o, bin_o, se_done_o;

    spec_bin_decoder dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_ctx_i(start_ctx_i),
        .start_bypass_i(start_bypass_i), .bit_i(bit_i), .bit_valid_i(bit_valid_i),
        .bit_ready_o(bit_ready_o), .bin_valid_o(bin_valid_o), .bin_o(bin_o),
        .se_done_o(se_done_o)
    );

    always #4 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    logic stream [NBITS];
    int sptr = 0;
    bit take_pend = 0;
    int valid_mode = 0;

    // reference model state
    int m_rng, m_off, m_ptr;
    int m_st [64];
    int m_mps [64];
    int m_base, m_k;
    bit m_byp;
    bit busy_m = 0;
    bit mon_on = 0;
    int last_bin_cyc = -10;

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    // stream source: drives at the falling edge, advances on accepted bits
    always @(negedge clk) begin
        if (take_pend) sptr++;
        bit_i = stream[sptr % NBITS];
        case (valid_mode)
            0: bit_valid_i = 1'b1;
            1: bit_valid_i = ((cyc % 3) != 2);
            default: bit_valid_i = 1'b0;
        endcase
        take_pend = bit_valid_i && bit_ready_o && rst_n;
    end

    function automatic int next_bit();
        int b;
        b = int'(stream[m_ptr % NBITS]);
        m_ptr++;
        return b;
    endfunction

    // unlikely width per R2
    function automatic int b_lps(input int s, input int q);
        int p, v;
        p = 32768;
        repeat (s) p = p * 243 / 256;
        v = p * 32 * (2 * q + 9) / 65536;
        return (v < 6) ? 6 : v;
    endfunction

    function automatic int model_bin();
        int c, s, l, rm, b;
        if (m_byp) begin
            m_off = 2 * m_off + next_bit();
            if (m_off >= m_rng) begin b = 1; m_off -= m_rng; end
            else b = 0;
            return b;
        end
        c  = (m_base + ((m_k < 3) ? m_k : 3)) % 64;
        s  = m_st[c];
        l  = b_lps(s, (m_rng / 64) % 4);
        rm = m_rng - l;
        if (m_off >= rm) begin
            b = 1 - m_mps[c];
            m_off -= rm;
            m_rng = l;
            if (s == 0) m_mps[c] = 1 - m_mps[c];
            m_st[c] = (s == 0) ? 0 : s - 1 - s / 4;
        end else begin
            b = m_mps[c];
            m_rng = rm;
            m_st[c] = (s >= 62) ? 62 : s + 1;
        end
        while (m_rng < 256) begin
            m_rng = 2 * m_rng;
            m_off = 2 * m_off + next_bit();
        end
        return b;
    endfunction

    // bin monitor
    always @(negedge clk) begin
        if (rst_n && mon_on && bin_valid_o) begin
            if (!busy_m) begin
                check(1'b0, "R9 bin without accepted element", 1, 0);
            end else begin
                int eb;
                bit ed;
                if (m_byp && m_k > 0 && valid_mode == 0)
                    check(cyc == last_bin_cyc + 1, "R7 back-to-back bin cycle", cyc, last_bin_cyc + 1);
                eb = model_bin();
                ed = (eb == 0) || (m_k == MAXB - 1);
                if (m_byp) check(int'(bin_o) == eb, "R5 bypass bin", int'(bin_o), eb);
                else       check(int'(bin_o) == eb, "R2 R3 R4 R7 context bin", int'(bin_o), eb);
                check(se_done_o == ed, "R6 element end flag", int'(se_done_o), int'(ed));
                last_bin_cyc = cyc;
                if (ed) busy_m = 0;
                else m_k++;
            end
        end
    end

    task automatic issue(input int c, input bit byp, input bit spur);
        while (busy_m) @(negedge clk);
        start_ctx_i    = 6'(c);
        start_bypass_i = byp;
        start_i        = 1'b1;
        m_base = c; m_byp = byp; m_k = 0; busy_m = 1;
        @(negedge clk);
        if (spur) begin
            // R9: second start while the element is in flight
            start_ctx_i    = 6'(c ^ 5);
            start_bypass_i = !byp;
            @(negedge clk);
        end
        start_i = 1'b0;
    endtask

    initial begin
        logic [15:0] lf;
        lf = 16'hACE1;
        for (int i = 0; i < NBITS; i++) begin
            stream[i] = lf[0];
            lf = {lf[0] ^ lf[2] ^ lf[3] ^ lf[5], lf[15:1]};
        end
        for (int i = 0; i < 64; i++) begin m_st[i] = 0; m_mps[i] = 0; end

        repeat (3) @(negedge clk);
        check(bin_valid_o == 1'b0, "R1 no bin in reset", int'(bin_valid_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(bit_ready_o == 1'b1, "R1 ready during initial fetch", int'(bit_ready_o), 1);
        check(bin_valid_o == 1'b0, "R1 no bin during initial fetch", int'(bin_valid_o), 0);

        m_rng = 510; m_off = 0; m_ptr = 0;
        for (int i = 0; i < 9; i++) m_off = 2 * m_off + next_bit();
        mon_on = 1;

        repeat (20) @(negedge clk);
        check(bit_ready_o == 1'b0, "R8 ready low when idle", int'(bit_ready_o), 0);
        check(sptr == 9, "R1 initial fetch length", sptr, 9);

        for (int pass = 0; pass < 3; pass++) begin
            valid_mode = (pass == 1) ? 1 : 0;
            for (int c = 0; c < 64; c++) begin
                issue(c, 1'b0, (c % 8) == 3);
                if ((c % 4) == 0) issue(c, 1'b1, (c % 16) == 4);
            end
        end

        // R8: a bypass bin waits for a valid stream bit
        while (busy_m) @(negedge clk);
        valid_mode = 0;
        repeat (12) @(negedge clk);
        valid_mode = 2;
        @(negedge clk);
        issue(7, 1'b1, 1'b0);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            check(bin_valid_o == 1'b0, "R8 no bin while stream stalled", int'(bin_valid_o), 0);
        end
        valid_mode = 0;
        while (busy_m) @(negedge clk);

        repeat (10) @(negedge clk);
        summary();
    end
endmodule